// File: doc/BRIEF.md
# Interlaced Still-Capture Sequencer

This block steps a camera front end through one still-image capture. In live view it leaves the timing generator in movie mode, the shutter open and the frame memory in normal operation. A record request puts the timing generator into still mode. The block then waits for the exposure to end and closes the mechanical shutter. Next it takes one odd field and then one even field from the interlaced sensor, and weaves their lines into a single progressive frame in the frame buffer.

Once both fields are stored, the block gives the external compressor a one-cycle start. It holds the memory idle while compression runs. When the compressor reports completion, the block raises a one-cycle done pulse and returns to live view. The sensor, the compressor and the memory appear here only as handshake strobes. Each field carries a parameterised number of lines.

Top module: `still_capture_seq`

## Requirements
- R1: After a synchronous reset the block is in live view. `tg_still`, `shutter_close`, `wr_en`, `enc_start` and `cap_done` are 0, and `mem_mode` is 0 (normal).
- R2: A `rec_req` sampled high in live view sets `tg_still` to 1 (still mode) in the next cycle. The shutter stays open until the exposure ends.
- R3: An `exp_done` sampled while exposing sets `shutter_close` to 1 in the next cycle. It stays 1 until the capture sequence returns to live view.
- R4: After the shutter closes, capture starts only at a `fld_start` with `fld_odd`=1. A `fld_start` with `fld_odd`=0 that comes first is ignored.
- R5: During a field being read, each `line_vld` raises `wr_en` in the same cycle. For line n of the field, `wr_addr` is 2n in the odd field and 2n+1 in the even field. Line n is the n-th strobe, counted from 0.
- R6: After LINES odd lines the block waits for a `fld_start` with `fld_odd`=0. After LINES even lines, `enc_start` is high for exactly one cycle, in the cycle after the last even line.
- R7: `mem_mode` is encoded 0 = normal, 1 = write-only, 2 = no operation. It is 0 in live view and during exposure. It is 1 from shutter close until the last even line. It is 2 from the compressor start until completion.
- R8: An `enc_done` that arrives while waiting for the compressor raises `cap_done` in the same cycle. In the next cycle `tg_still` and `shutter_close` are 0 and `mem_mode` is 0.
- R9: A `rec_req` during exposure, capture or compression has no effect. After the sequence ends, the block stays in live view with `tg_still` at 0.
- R10: A `line_vld` outside the two read fields produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req | input | 1 | Record button request |
| exp_done | input | 1 | Exposure finished strobe |
| fld_start | input | 1 | Start of a sensor field |
| fld_odd | input | 1 | Field parity at `fld_start` (1 = odd) |
| line_vld | input | 1 | One sensor line delivered |
| enc_done | input | 1 | Compressor finished strobe |
| tg_still | output | 1 | Timing generator mode (1 = still, 0 = movie) |
| shutter_close | output | 1 | Mechanical shutter close command |
| mem_mode | output | 2 | Memory mode: 0 normal, 1 write-only, 2 no operation |
| wr_en | output | 1 | Frame buffer line write |
| wr_addr | output | clog2(2*LINES) | Woven frame line address |
| enc_start | output | 1 | One-cycle compressor start |
| cap_done | output | 1 | One-cycle capture complete |

## Verification
The bench builds the block with LINES = 4, so the frame address is 3 bits. At that size, both wraps of the line counter and every woven address from 0 to 7 appear within a few dozen cycles. Two full captures run back to back with different gaps. Across them, a stray even field, stray line strobes and repeated record requests fall into every waiting phase.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;
    typedef enum logic [2:0] {
        ST_LIVE     = 3'd0,
        ST_EXPOSE   = 3'd1,
        ST_WAIT_ODD = 3'd2,
        ST_RD_ODD   = 3'd3,
        ST_WAIT_EVN = 3'd4,
        ST_RD_EVN   = 3'd5,
        ST_KICK     = 3'd6,
        ST_ENC_WAIT = 3'd7
    } cap_state_e;

    typedef enum logic [1:0] {
        MM_NORMAL = 2'd0,
        MM_WRONLY = 2'd1,
        MM_IDLE   = 2'd2
    } mem_mode_e;

    typedef struct packed {
        logic      tg_still;
        logic      shutter;
        mem_mode_e mode;
        logic      reading;
        logic      even;
        logic      kick;
    } stc_ctl_t;

    function automatic stc_ctl_t decode_state(cap_state_e s);
        stc_ctl_t c;
        c.tg_still = (s != ST_LIVE);
        c.shutter  = (s != ST_LIVE) && (s != ST_EXPOSE);
        c.reading  = (s == ST_RD_ODD) || (s == ST_RD_EVN);
        c.even     = (s == ST_RD_EVN);
        c.kick     = (s == ST_KICK);
        if (s == ST_KICK || s == ST_ENC_WAIT)
            c.mode = MM_IDLE;
        else if (c.shutter)
            c.mode = MM_WRONLY;
        else
            c.mode = MM_NORMAL;
        return c;
    endfunction
endpackage

// File: rtl/stc_ctrl.sv
`timescale 1ns/1ps
module stc_ctrl
    import stc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rec_req,
    input  logic       exp_done,
    input  logic       fld_start,
    input  logic       fld_odd,
    input  logic       field_last,
    input  logic       enc_done,
    output cap_state_e state,
    output logic       done
);
    cap_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LIVE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LIVE:     if (rec_req)               nxt = ST_EXPOSE;
            ST_EXPOSE:   if (exp_done)              nxt = ST_WAIT_ODD;
            ST_WAIT_ODD: if (fld_start && fld_odd)  nxt = ST_RD_ODD;
            ST_RD_ODD:   if (field_last)            nxt = ST_WAIT_EVN;
            ST_WAIT_EVN: if (fld_start && !fld_odd) nxt = ST_RD_EVN;
            ST_RD_EVN:   if (field_last)            nxt = ST_KICK;
            ST_KICK:                                nxt = ST_ENC_WAIT;
            ST_ENC_WAIT: if (enc_done)              nxt = ST_LIVE;
            default:                                nxt = ST_LIVE;
        endcase
    end

    assign done = (state == ST_ENC_WAIT) && enc_done;
endmodule

// File: rtl/stc_weave.sv
`timescale 1ns/1ps
module stc_weave #(
    parameter int LINES = 240,
    parameter int LW    = 8,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          even,
    input  logic          line_vld,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          last
);
    localparam logic [LW-1:0] LAST_IDX = LW'(LINES - 1);

    logic [LW-1:0] line_cnt;

    assign wr_en   = active && line_vld;
    assign last    = wr_en && (line_cnt == LAST_IDX);
    assign wr_addr = AW'({line_cnt, even});

    always_ff @(posedge clk) begin
        if (rst || !active)
            line_cnt <= '0;
        else if (wr_en)
            line_cnt <= last ? '0 : line_cnt + 1'b1;
    end
endmodule

// File: rtl/still_capture_seq.sv
`timescale 1ns/1ps
module still_capture_seq
    import stc_pkg::*;
#(
    parameter int LINES = 240,
    localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int AW   = LW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rec_req,
    input  logic          exp_done,
    input  logic          fld_start,
    input  logic          fld_odd,
    input  logic          line_vld,
    input  logic          enc_done,
    output logic          tg_still,
    output logic          shutter_close,
    output logic [1:0]    mem_mode,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          enc_start,
    output logic          cap_done
);
    cap_state_e state;
    stc_ctl_t   ctl;
    logic       field_last;

    stc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rec_req    (rec_req),
        .exp_done   (exp_done),
        .fld_start  (fld_start),
        .fld_odd    (fld_odd),
        .field_last (field_last),
        .enc_done   (enc_done),
        .state      (state),
        .done       (cap_done)
    );

    assign ctl = decode_state(state);

    stc_weave #(.LINES(LINES), .LW(LW), .AW(AW)) u_weave (
        .clk      (clk),
        .rst      (rst),
        .active   (ctl.reading),
        .even     (ctl.even),
        .line_vld (line_vld),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .last     (field_last)
    );

    assign tg_still      = ctl.tg_still;
    assign shutter_close = ctl.shutter;
    assign mem_mode      = ctl.mode;
    assign enc_start     = ctl.kick;
endmodule

// File: rtl/still_capture_seq_chk.sv
`timescale 1ns/1ps
module still_capture_seq_chk #(
    parameter int LINES = 240,
    localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int AW   = LW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          rec_req,
    input logic          enc_done,
    input logic          tg_still,
    input logic          shutter_close,
    input logic [1:0]    mem_mode,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          enc_start,
    input logic          cap_done
);
    p_still_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        (!tg_still && rec_req) |=> tg_still);

    p_shutter_in_still_r3: assert property (@(posedge clk) disable iff (rst)
        shutter_close |-> tg_still);

    p_write_only_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (mem_mode == 2'd1) && shutter_close);

    p_kick_single_r6: assert property (@(posedge clk) disable iff (rst)
        enc_start |=> !enc_start && (mem_mode == 2'd2));

    p_kick_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(enc_start) |-> $past(wr_en) && $past(wr_addr[0]));

    p_idle_mode_r7: assert property (@(posedge clk) disable iff (rst)
        enc_start |-> mem_mode == 2'd2);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        cap_done |=> !tg_still && !shutter_close && (mem_mode == 2'd0));

    p_done_on_ack_r8: assert property (@(posedge clk) disable iff (rst)
        cap_done |-> enc_done && (mem_mode == 2'd2));

    p_pulses_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, enc_start, cap_done}));

    p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (rst)
        (shutter_close && !cap_done && rec_req) |=> tg_still);
endmodule

bind still_capture_seq still_capture_seq_chk #(.LINES(LINES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rec_req       (rec_req),
    .enc_done      (enc_done),
    .tg_still      (tg_still),
    .shutter_close (shutter_close),
    .mem_mode      (mem_mode),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .enc_start     (enc_start),
    .cap_done      (cap_done)
);

// File: tb/still_capture_seq_test.sv
`timescale 1ns/1ps
module still_capture_seq_test;
    localparam int L  = 4;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rec_req = 0, exp_done = 0, fld_start = 0, fld_odd = 0, line_vld = 0, enc_done = 0;
    logic tg_still, shutter_close, wr_en, enc_start, cap_done;
    logic [1:0] mem_mode;
    logic [AW-1:0] wr_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int ph = 0;
    int lc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    still_capture_seq #(.LINES(L)) uut (
        .clk(clk), .rst(rst), .rec_req(rec_req), .exp_done(exp_done),
        .fld_start(fld_start), .fld_odd(fld_odd), .line_vld(line_vld),
        .enc_done(enc_done), .tg_still(tg_still), .shutter_close(shutter_close),
        .mem_mode(mem_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .enc_start(enc_start), .cap_done(cap_done)
    );

    // Behavioural reference: phase 0 live, 1 exposing, 2 awaiting odd,
    // 3 odd lines, 4 awaiting even, 5 even lines, 6 start, 7 compressing.
    always @(posedge clk) begin
        if (rst) begin
            ph <= 0; lc <= 0;
        end else begin
            if (ph == 0 && rec_req) ph <= 1;
            else if (ph == 1 && exp_done) ph <= 2;
            else if (ph == 2 && fld_start && fld_odd) begin ph <= 3; lc <= 0; end
            else if (ph == 4 && fld_start && !fld_odd) begin ph <= 5; lc <= 0; end
            else if ((ph == 3 || ph == 5) && line_vld) begin
                if (lc == L - 1) begin lc <= 0; ph <= ph + 1; end
                else lc <= lc + 1;
            end
            else if (ph == 6) ph <= 7;
            else if (ph == 7 && enc_done) ph <= 0;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            int e_mm;
            bit e_we;
            e_mm = (ph >= 2 && ph <= 5) ? 1 : (ph >= 6 ? 2 : 0);
            e_we = (ph == 3 || ph == 5) && line_vld;
            chk("R2", "tg_still", tg_still, ph != 0);
            chk("R3", "shutter_close", shutter_close, ph >= 2);
            chk("R7", "mem_mode", mem_mode, e_mm);
            chk("R10", "wr_en", wr_en, e_we);
            if (e_we) chk("R5", "wr_addr", wr_addr, lc * 2 + (ph == 5 ? 1 : 0));
            chk("R6", "enc_start", enc_start, ph == 6);
            chk("R8", "cap_done", cap_done, (ph == 7) && enc_done);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic lines(int gap);
        for (int i = 0; i < L; i++) begin
            line_vld = 1; step(); line_vld = 0; step(gap);
        end
    endtask

    task automatic capture(int gap);
        rec_req = 1; step(); rec_req = 0; step(gap);
        rec_req = 1; step(); rec_req = 0;          // R9 during exposure
        exp_done = 1; step(); exp_done = 0; step();
        fld_start = 1; fld_odd = 0; step(); fld_start = 0; step();  // R4 stray even
        line_vld = 1; step(); line_vld = 0; step(); // R10 stray line
        chk("R4", "mem_mode after stray even", mem_mode, 1);
        fld_start = 1; fld_odd = 1; step(); fld_start = 0; step(gap);
        lines(gap);
        rec_req = 1; step(); rec_req = 0;          // R9 between fields
        fld_start = 1; fld_odd = 0; step(); fld_start = 0;
        lines(gap);
        line_vld = 1; rec_req = 1; step(); line_vld = 0; rec_req = 0; step(gap + 1);
        enc_done = 1; step(); enc_done = 0; step();
        chk("R8", "tg_still after done", tg_still, 0);
    endtask

    initial begin
        step(3);
        chk("R1", "tg_still in reset", tg_still, 0);
        chk("R1", "mem_mode in reset", mem_mode, 0);
        rst = 0; step(2);
        chk("R1", "shutter after reset", shutter_close, 0);
        capture(0);
        capture(2);
        step(4);
        chk("R9", "tg_still idle after sequence", tg_still, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule